// File: doc/BRIEF.md
# Multi-Cycle Multiply/Divide Unit with Dedicated HI/LO Registers

This block performs unsigned 32-bit multiplication and unsigned 32-bit division over many clock cycles. It keeps its results in a private pair of registers, HI and LO, instead of the general register file. A core issues a start pulse with an operation select and two operands. The unit then raises a busy flag while it works through one result bit per clock. When it finishes, it writes HI and LO together and pulses a done flag for one cycle. Two read ports always show the current HI and LO contents, so move-from-HI and move-from-LO reads need no extra cycle.

The multiplier uses the shift-and-add method. The divider uses restoring division. A multiply leaves the 64-bit product split across the pair, with the upper half in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. The busy flag is the only way the caller waits for a result. There is no queueing: a start that arrives while busy is dropped.

Top module: `hilo_arith_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy and done are low and both HI and LO read zero.
- R2: When start is high while busy is low, busy is high in the next cycle and stays high for exactly 32 cycles.
- R3: Done is high for exactly one cycle. That cycle is the first cycle in which busy is low again and in which HI and LO show the new result.
- R4: With the operation select at 0 (multiply), the operands are unsigned. HI receives bits 63..32 of the 64-bit product and LO receives bits 31..0.
- R5: With the operation select at 1 (unsigned divide) and a nonzero divisor (operand B), LO receives the quotient A/B and HI receives the remainder A%B.
- R6: An unsigned divide by zero writes all ones (0xFFFFFFFF) to LO and writes the dividend A unchanged to HI.
- R7: A start that arrives while busy is high has no effect. The running operation keeps its operands, operation and completion cycle.
- R8: HI and LO change only in a cycle where done is high. Otherwise they hold their values.
- R9: A start issued in the done cycle is accepted, so operations can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| op_i | input | 1 | Operation select: 0 multiply, 1 unsigned divide |
| opa_i | input | 32 | Operand A: multiplicand or dividend |
| opb_i | input | 32 | Operand B: multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when HI/LO are written |
| hi_o | output | 32 | HI register: upper product half or remainder |
| lo_o | output | 32 | LO register: lower product half or quotient |

## Verification
The assertions check the following on every cycle:
- done lasts a single cycle and follows the last iteration, with busy falling at the same time;
- an accepted start raises busy;
- a start that arrives while busy leaves the captured operation unchanged;
- HI and LO never move outside a done cycle;
- each divider step keeps the partial remainder below a nonzero divisor;
- a zero divisor always produces a quotient bit of one.

The arithmetic values themselves only appear when the bench runs its scenarios. These are the reference model comparisons for:
- extreme operands;
- dividend smaller than divisor;
- division by zero;
- a dropped start with conflicting operands;
- a start issued in the done cycle.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic {
    OP_MUL  = 1'b0,
    OP_DIVU = 1'b1
  } hilo_op_e;
endpackage

// File: rtl/hilo_seq.sv
module hilo_seq #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o,
  output logic last_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last_o = busy_q & (cnt_q == LAST_CNT);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = last_o;
    if (load_o) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (last_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> busy_o);
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (done_o && !busy_o));
  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/hilo_mul_eng.sv
module hilo_mul_eng #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] nxt_hi_o,
  output logic [W-1:0] nxt_lo_o
);
  localparam int PW = 2 * W;

  logic [W-1:0]  mcand_q, mcand_d;
  logic [PW-1:0] prod_q, prod_d, prod_step;
  logic [W:0]    sum;
  logic          en;

  assign en = load_i | step_i;

  always_comb begin
    sum       = {1'b0, prod_q[PW-1:W]} + (prod_q[0] ? {1'b0, mcand_q} : '0);
    prod_step = {sum, prod_q[W-1:1]};
    mcand_d   = mcand_q;
    prod_d    = prod_q;
    if (load_i) begin
      mcand_d = a_i;
      prod_d  = {{W{1'b0}}, b_i};
    end else if (step_i) begin
      prod_d = prod_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else if (en) begin
      mcand_q <= mcand_d;
      prod_q  <= prod_d;
    end
  end

  assign nxt_hi_o = prod_step[PW-1:W];
  assign nxt_lo_o = prod_step[W-1:0];
endmodule

// File: rtl/hilo_div_eng.sv
module hilo_div_eng #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] nxt_rem_o,
  output logic [W-1:0] nxt_quo_o
);
  logic [W-1:0] dvsr_q, dvsr_d;
  logic [W-1:0] rem_q, rem_d, rem_step;
  logic [W-1:0] quo_q, quo_d, quo_step;
  logic [W:0]   shifted;
  logic [W-1:0] diff;
  logic         fits;
  logic         en;

  assign en = load_i | step_i;

  always_comb begin
    shifted  = {rem_q, quo_q[W-1]};
    fits     = (shifted >= {1'b0, dvsr_q});
    diff     = shifted[W-1:0] - dvsr_q;
    rem_step = fits ? diff : shifted[W-1:0];
    quo_step = {quo_q[W-2:0], fits};
    dvsr_d   = dvsr_q;
    rem_d    = rem_q;
    quo_d    = quo_q;
    if (load_i) begin
      dvsr_d = b_i;
      rem_d  = '0;
      quo_d  = a_i;
    end else if (step_i) begin
      rem_d = rem_step;
      quo_d = quo_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvsr_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else if (en) begin
      dvsr_q <= dvsr_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
    end
  end

  assign nxt_rem_o = rem_step;
  assign nxt_quo_o = quo_step;

  // R5
  rem_below_dvsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && dvsr_q != '0) |=> (rem_q < dvsr_q));
  // R6
  zero_dvsr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && dvsr_q == '0) |=> quo_q[0]);
endmodule

// File: rtl/hilo_arith_unit.sv
module hilo_arith_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  import hilo_pkg::*;

  logic         load, step, last;
  hilo_op_e     op_q, op_d;
  logic [W-1:0] mul_hi, mul_lo, div_rem, div_quo;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;

  hilo_seq #(.W(W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last)
  );

  hilo_mul_eng #(.W(W)) mul_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load & (op_i == OP_MUL)),
    .step_i   (step & (op_q == OP_MUL)),
    .a_i      (opa_i),
    .b_i      (opb_i),
    .nxt_hi_o (mul_hi),
    .nxt_lo_o (mul_lo)
  );

  hilo_div_eng #(.W(W)) div_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load & (op_i == OP_DIVU)),
    .step_i    (step & (op_q == OP_DIVU)),
    .a_i       (opa_i),
    .b_i       (opb_i),
    .nxt_rem_o (div_rem),
    .nxt_quo_o (div_quo)
  );

  always_comb begin
    op_d = load ? hilo_op_e'(op_i) : op_q;
    hi_d = hi_q;
    lo_d = lo_q;
    if (last) begin
      hi_d = (op_q == OP_MUL) ? mul_hi : div_rem;
      lo_d = (op_q == OP_MUL) ? mul_lo : div_quo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_MUL;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (load) op_q <= op_d;
      if (last) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R7
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(op_q));
  // R8
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hi_o) |-> done_o);
  // R8
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lo_o) |-> done_o);
endmodule

// File: tb/hilo_arith_unit_tb_top.sv
module hilo_arith_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        busy_o, done_o;
  logic [31:0] hi_o, lo_o;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  hilo_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
    .hi_o(hi_o), .lo_o(lo_o)
  );

  // behavioural reference model
  bit          m_busy, m_done, m_op;
  int          m_cnt;
  logic [31:0] m_a, m_b, m_hi, m_lo;
  logic [63:0] m_prod;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_hi = 0; m_lo = 0;
      m_op = 0; m_a = 0; m_b = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 32) begin
          m_busy = 0;
          m_done = 1;
          if (!m_op) begin
            m_prod = {32'd0, m_a} * {32'd0, m_b};
            m_hi = m_prod[63:32];
            m_lo = m_prod[31:0];
          end else if (m_b == 0) begin
            m_hi = m_a;
            m_lo = 32'hFFFF_FFFF;
          end else begin
            m_hi = m_a % m_b;
            m_lo = m_a / m_b;
          end
        end
      end else if (start_i) begin
        m_busy = 1; m_cnt = 0; m_op = op_i; m_a = opa_i; m_b = opb_i;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(busy_o == m_busy, "R2 busy", 32'(busy_o), 32'(m_busy));
      chk(done_o == m_done, "R3 done", 32'(done_o), 32'(m_done));
      chk(hi_o == m_hi, m_done ? (m_op ? "R5/R6 hi" : "R4 hi") : "R8 hi",
          hi_o, m_hi);
      chk(lo_o == m_lo, m_done ? (m_op ? "R5/R6 lo" : "R4 lo") : "R8 lo",
          lo_o, m_lo);
    end
  end

  task automatic issue(input bit op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start_i = 1; op_i = op; opa_i = a; opb_i = b;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  task automatic run_op(input bit op, input logic [31:0] a, input logic [31:0] b,
                        input string tag, input logic [31:0] ehi,
                        input logic [31:0] elo);
    issue(op, a, b);
    wait_done();
    chk(hi_o == ehi, tag, hi_o, ehi);
    chk(lo_o == elo, tag, lo_o, elo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy_o == 0 && done_o == 0, "R1 flags", {30'd0, busy_o, done_o}, 32'd0);
    chk(hi_o == 0 && lo_o == 0, "R1 hilo", hi_o | lo_o, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_o == 0 && hi_o == 0 && lo_o == 0, "R1 after release", hi_o, 32'd0);

    // R4 multiply patterns
    run_op(0, 32'd3, 32'd5, "R4 small", 32'd0, 32'd15);
    run_op(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4 max", 32'hFFFF_FFFE, 32'd1);
    run_op(0, 32'h8000_0000, 32'd2, "R4 carry", 32'd1, 32'd0);
    run_op(0, 32'h1234_5678, 32'd0, "R4 zero", 32'd0, 32'd0);
    // R5 divide patterns
    run_op(1, 32'd100, 32'd7, "R5 basic", 32'd2, 32'd14);
    run_op(1, 32'd5, 32'd9, "R5 small dividend", 32'd5, 32'd0);
    run_op(1, 32'hFFFF_FFFF, 32'd1, "R5 div by one", 32'd0, 32'hFFFF_FFFF);
    run_op(1, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R5 near max", 32'hFFFF_FFFE, 32'd0);
    // R6 divide by zero
    run_op(1, 32'h1234_5678, 32'd0, "R6 div zero", 32'h1234_5678, 32'hFFFF_FFFF);
    run_op(1, 32'd0, 32'd0, "R6 zero by zero", 32'd0, 32'hFFFF_FFFF);

    // R2: busy duration counted at the ports
    begin
      int span = 0;
      issue(0, 32'd7, 32'd6);
      span = 1;
      while (busy_o) begin
        @(negedge clk);
        if (busy_o) span++;
      end
      chk(span == 32, "R2 busy length", 32'(span), 32'd32);
      chk(done_o == 1, "R3 done with busy low", 32'(done_o), 32'd1);
      @(negedge clk);
      chk(done_o == 0, "R3 done width", 32'(done_o), 32'd0);
    end

    // R7: conflicting start while busy is dropped
    issue(1, 32'd1000, 32'd3);
    repeat (5) @(negedge clk);
    start_i = 1; op_i = 0; opa_i = 32'd9; opb_i = 32'd9;
    @(negedge clk);
    start_i = 0;
    wait_done();
    chk(lo_o == 32'd333 && hi_o == 32'd1, "R7 ignored start", lo_o, 32'd333);
    @(negedge clk);
    chk(busy_o == 0, "R7 no extra run", 32'(busy_o), 32'd0);

    // R8: idle hold
    repeat (4) @(negedge clk);
    chk(lo_o == 32'd333, "R8 hold", lo_o, 32'd333);

    // R9: back-to-back start in the done cycle
    issue(0, 32'd11, 32'd13);
    wait_done();
    start_i = 1; op_i = 1; opa_i = 32'd50; opb_i = 32'd8;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1, "R9 back to back accepted", 32'(busy_o), 32'd1);
    wait_done();
    chk(lo_o == 32'd6 && hi_o == 32'd2, "R9 second result", lo_o, 32'd6);

    // mixed pseudo-random operations
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      bit op;
      a = $urandom; b = (i % 5 == 0) ? 32'($urandom_range(0, 15)) : $urandom;
      op = i[0];
      issue(op, a, b);
      wait_done();
    end

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule